// File: doc/BRIEF.md
# FIFO Error and Event Counter Status Word

This block holds a 32-bit read-only status word that gathers latched error flags from two video FIFOs and four audio FIFOs, and latched threshold flags from four event counters. It also mirrors two live video gate signals. Each flag is set by a one-cycle pulse from its source and stays set until something clears it. The FIFOs, counters and DMA engines are outside the block; they appear only as input strobes.

A flag is never cleared by writing the status word. Clearing happens in two ways. The first is a write to a companion acknowledge register, where one bit clears a whole group: all video flags, all audio flags or all event counter flags. The second is a per-channel DMA event: a base-address reload for a video channel, or a restart for an audio channel. When a set and a clear reach the same flag in the same cycle, the set wins. The bus reads the word at byte offset 0x114 through a registered read port.

Top module: `fes_status_reg`

## Requirements
- R1: A synchronous reset clears every latched flag. The first read after reset returns 0 when both gate inputs are low.
- R2: A pulse on `vid_err_i[0]` (video FIFO 1 overflow) sets bit 11. A pulse on `vid_err_i[1]` (video FIFO 2 overflow or underflow) sets bit 12. Both bits stay set after the pulse ends.
- R3: A video flag clears when `vid_reload_i` pulses for its own channel, with no effect on the other channel. It also clears when `ack_we_i` and `ack_vid_i` are both 1.
- R4: Pulses on `aud_err_i[3]` (input FIFO 2 underflow), `aud_err_i[2]` (output FIFO 2 overflow), `aud_err_i[1]` (input FIFO 1 underflow) and `aud_err_i[0]` (output FIFO 1 overflow) set bits 10, 9, 8 and 7 of the word. Each bit stays set after its pulse ends.
- R5: An audio flag clears when `aud_restart_i` pulses for its own channel. All four audio flags clear together when `ack_we_i` and `ack_aud_i` are both 1.
- R6: Pulses on `evt_hit_i[3:0]` (counters 5, 4, 2 and 1) set bits 3 to 0 and the bits stay set. All four clear together when `ack_we_i` and `ack_evt_i` are both 1.
- R7: When a set pulse and any clear source reach the same flag in the same cycle, the flag is 1 afterwards.
- R8: Bits 31 to 13 and bit 6 always read 0. Bit 5 reads the level of `vgate_i` and bit 4 the level of `hgate_i`, as they were in the read cycle. These two bits are never latched.
- R9: An acknowledge write whose group bits are all 0 changes no flag. Group bits given while `ack_we_i` is 0 also change no flag.
- R10: A read with `rd_en_i` high at `rd_addr_i` = 0x114 loads the word into `rd_data_o` one clock later. A read at any other address loads 0. While `rd_en_i` is low, `rd_data_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_err_i | input | 2 | Video FIFO error pulses, index = channel - 1 |
| aud_err_i | input | 4 | Audio FIFO error pulses: out1 ovf, in1 udf, out2 ovf, in2 udf |
| evt_hit_i | input | 4 | Event counter threshold pulses: counters 1, 2, 4, 5 |
| vid_reload_i | input | 2 | Video DMA base-address reload strobes, per channel |
| aud_restart_i | input | 4 | Audio DMA restart strobes, same indexing as aud_err_i |
| ack_we_i | input | 1 | Write strobe of the acknowledge register |
| ack_vid_i | input | 1 | Acknowledge data: clear all video flags |
| ack_aud_i | input | 1 | Acknowledge data: clear all audio flags |
| ack_evt_i | input | 1 | Acknowledge data: clear all event counter flags |
| vgate_i | input | 1 | Live vertical gate |
| hgate_i | input | 1 | Live horizontal line gate |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 12 | Byte address of the read |
| rd_data_o | output | 32 | Registered read data |

## Verification
The main risk is a set pulse and a clear that land on the same flag in the same cycle. The clear can come from a group acknowledge or from a per-channel reload or restart. The bench drives all error, hit, clear and gate inputs from a pseudo-random sequence, so these collisions occur many times on every flag. It also runs directed collisions on single bits. Each read is compared with an arithmetic model in the bench, in which a set overrides a clear. Any lost event shows up as a cleared bit where the model expects 1.

// File: rtl/fes_pkg.sv
package fes_pkg;
  localparam int WORD_W    = 32;
  localparam int N_VID     = 2;
  localparam int N_AUD     = 4;
  localparam int N_EVT     = 4;
  localparam int N_FLAG    = N_VID + N_AUD + N_EVT;
  localparam int EVT_LSB   = 0;
  localparam int HGATE_BIT = 4;
  localparam int VGATE_BIT = 5;
  localparam int RSVD_BIT  = 6;
  localparam int AUD_LSB   = 7;
  localparam int VID_LSB   = AUD_LSB + N_AUD;
  localparam int TOP_USED  = VID_LSB + N_VID;
endpackage

// File: rtl/fes_sticky_bank.sv
module fes_sticky_bank #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_o[g] <= 1'b0;
      else if (set_i[g])  flag_o[g] <= 1'b1;
      else if (clr_i[g])  flag_o[g] <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_i[g] |=> flag_o[g]); // R7
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (!set_i[g] && clr_i[g]) |=> !flag_o[g]); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!set_i[g] && !clr_i[g]) |=> $stable(flag_o[g])); // R9
  end
endmodule

// File: rtl/fes_read_port.sv
module fes_read_port #(
  parameter int                ADDR_W = 12,
  parameter int                DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h114
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic hit;
  assign hit = (rd_addr_i == OFFSET);

  always_ff @(posedge clk) begin
    if (rst)          rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= hit ? word_i : '0;
  end

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !hit) |=> (rd_data_o == '0)); // R10
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o)); // R10
endmodule

// File: rtl/fes_status_reg.sv
module fes_status_reg
  import fes_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h114
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_VID-1:0]  vid_err_i,
  input  logic [N_AUD-1:0]  aud_err_i,
  input  logic [N_EVT-1:0]  evt_hit_i,
  input  logic [N_VID-1:0]  vid_reload_i,
  input  logic [N_AUD-1:0]  aud_restart_i,
  input  logic              ack_we_i,
  input  logic              ack_vid_i,
  input  logic              ack_aud_i,
  input  logic              ack_evt_i,
  input  logic              vgate_i,
  input  logic              hgate_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [N_FLAG-1:0] set_v, clr_v, flags;
  logic              grp_vid, grp_aud, grp_evt;
  logic [WORD_W-1:0] word;

  assign grp_vid = ack_we_i & ack_vid_i;
  assign grp_aud = ack_we_i & ack_aud_i;
  assign grp_evt = ack_we_i & ack_evt_i;

  // flag vector layout: {video, audio, event}
  assign set_v = {vid_err_i, aud_err_i, evt_hit_i};
  assign clr_v = {vid_reload_i | {N_VID{grp_vid}},
                  aud_restart_i | {N_AUD{grp_aud}},
                  {N_EVT{grp_evt}}};

  fes_sticky_bank #(.N(N_FLAG)) u_bank (
    .clk(clk), .rst(rst), .set_i(set_v), .clr_i(clr_v), .flag_o(flags)
  );

  always_comb begin
    word = '0;
    word[EVT_LSB +: N_EVT] = flags[0 +: N_EVT];
    word[HGATE_BIT]        = hgate_i;
    word[VGATE_BIT]        = vgate_i;
    word[RSVD_BIT]         = 1'b0;
    word[AUD_LSB +: N_AUD] = flags[N_EVT +: N_AUD];
    word[VID_LSB +: N_VID] = flags[N_EVT+N_AUD +: N_VID];
  end

  fes_read_port #(.ADDR_W(ADDR_W), .DATA_W(WORD_W), .OFFSET(OFFSET)) u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .word_i(word), .rd_data_o(rd_data_o)
  );

  AST_RST_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (flags == '0)); // R1
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_data_o[WORD_W-1:TOP_USED] == '0) && !rd_data_o[RSVD_BIT]); // R8
  AST_NO_STRAY_CLR: assert property (@(posedge clk) disable iff (rst)
    (!ack_we_i && vid_reload_i == '0 && !vid_err_i[0] && flags[N_EVT+N_AUD])
      |=> flags[N_EVT+N_AUD]); // R9
endmodule

// File: tb/sim_fes_status_reg.sv
module sim_fes_status_reg;
  logic        clk = 1'b0, rst = 1'b1;
  logic [1:0]  vid_err = '0, vid_rl = '0;
  logic [3:0]  aud_err = '0, aud_rs = '0, evt = '0;
  logic        ack_we = 0, ack_v = 0, ack_a = 0, ack_e = 0, vg = 0, hg = 0, rd_en = 0;
  logic [11:0] rd_addr = 12'h114;
  logic [31:0] rd_data;
  int n_chk = 0, n_bad = 0;
  logic [9:0]  model = '0;   // {vid[1:0], aud[3:0], evt[3:0]}
  logic [31:0] lfsr = 32'hACE1_2357;

  always #10 clk = ~clk;

  fes_status_reg u0 (
    .clk(clk), .rst(rst), .vid_err_i(vid_err), .aud_err_i(aud_err), .evt_hit_i(evt),
    .vid_reload_i(vid_rl), .aud_restart_i(aud_rs), .ack_we_i(ack_we), .ack_vid_i(ack_v),
    .ack_aud_i(ack_a), .ack_evt_i(ack_e), .vgate_i(vg), .hgate_i(hg),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  function automatic logic [31:0] mkword(logic [9:0] f, logic v, logic h);
    return {19'b0, f[9:8], f[7:4], 1'b0, v, h, f[3:0]};
  endfunction

  function automatic logic [9:0] nxt(logic [9:0] f);
    logic [9:0] s, c;
    s = {vid_err, aud_err, evt};
    c = {vid_rl | {2{ack_we & ack_v}}, aud_rs | {4{ack_we & ack_a}}, {4{ack_we & ack_e}}};
    return s | (f & ~c);
  endfunction

  task automatic check(string req, logic [31:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic idle();
    vid_err = '0; aud_err = '0; evt = '0; vid_rl = '0; aud_rs = '0;
    ack_we = 0; ack_v = 0; ack_a = 0; ack_e = 0;
  endtask

  // apply stimulus for one edge with a read at 0x114, then check the read
  task automatic step(string req);
    logic [31:0] e;
    rd_en = 1; rd_addr = 12'h114;
    e = mkword(model, vg, hg);
    model = nxt(model);
    @(negedge clk);
    check(req, e);
    idle();
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rd_en = 1;
    @(negedge clk);
    rst = 0;
    check("R1 reset read", 32'h0);
    step("R1 after reset");

    // R2 / R4 / R6: each flag set alone, then stays set
    vid_err = 2'b01; step("R2 set v1");
    step("R2 v1 sticky");
    vid_err = 2'b10; step("R2 set v2");
    aud_err = 4'b1000; step("R4 in2 udf");
    aud_err = 4'b0001; step("R4 out1 ovf");
    evt = 4'b1000; step("R6 counter5");
    evt = 4'b0001; step("R6 counter1");
    step("R2 R4 R6 readback");
    // R9: ack group bits without write strobe, write with zero group bits
    ack_v = 1; ack_a = 1; ack_e = 1; step("R9 no strobe");
    ack_we = 1; step("R9 zero group bits");
    step("R9 readback");
    // R3 per-channel reload
    vid_rl = 2'b01; step("R3 reload ch1");
    step("R3 ch1 cleared ch2 kept");
    // R5 per-channel restart
    aud_rs = 4'b1000; step("R5 restart in2");
    step("R5 readback");
    // R7 collision on a single bit with a group clear
    evt = 4'b0010; ack_we = 1; ack_e = 1; step("R7 set vs group clear");
    step("R7 counter2 kept");
    vid_err = 2'b10; vid_rl = 2'b10; step("R7 set vs reload");
    step("R7 video2 kept");
    // R8 gates live
    vg = 1; hg = 0; step("R8 vgate");
    vg = 0; hg = 1; step("R8 hgate");
    hg = 0;
    // R10 miss address and hold
    rd_addr = 12'h110; @(negedge clk); check("R10 miss reads 0", 32'h0);
    rd_en = 0; vg = 1; @(negedge clk); check("R10 hold", 32'h0);
    vg = 0; step("R10 resume");

    // near-exhaustive pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      vid_err = lfsr[1:0] & {2{lfsr[20]}};
      aud_err = lfsr[5:2] & {4{lfsr[21]}};
      evt     = lfsr[9:6] & {4{lfsr[22]}};
      vid_rl  = lfsr[11:10] & {2{lfsr[23] & lfsr[24]}};
      aud_rs  = lfsr[15:12] & {4{lfsr[25] & lfsr[24]}};
      ack_we  = lfsr[26] & lfsr[27];
      ack_v = lfsr[16]; ack_a = lfsr[17]; ack_e = lfsr[18];
      vg = lfsr[28]; hg = lfsr[29];
      step("R2-R8 sweep");
    end

    rst = 1; @(negedge clk); rst = 0; model = '0; vg = 0; hg = 0;
    step("R1 second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule